// File: doc/BRIEF.md
# Deep Sleep Exit Ramp Sequencer

This block sequences the way out of the deepest processor sleep state. While the processor sleeps, it holds the regulator in its deep-sleep setting. When a wake-up request arrives, it tells the voltage regulator, through two control lines, whether to raise the core voltage gently or at the usual rate. It then times the usual ramp and reports that the exit has finished with a single-cycle pulse.

A gentle ramp is used only when three conditions hold: software has enabled it, the wake-up was caused by a "slow" break event, and no "fast" event arrived in the same cycle. Slow events are typically periodic timer ticks, which would otherwise cause audible regulator noise. The gentle ramp adds a programmable waiting window before the usual ramp timer starts. A fast break event that arrives inside that window ends it at once and switches the regulator to the usual rate. Break events are classified upstream of this block.

Top module: `deep_exit_seq`

## Requirements
- R1: In the sleep state, which is also the state after reset, `vr_stop_no` is 0 and `vr_sleep_o` is 1.
- R2: When `exit_req_i` is sampled in the sleep state with `slow_en_i`=1, `slow_evt_i`=1, `fast_evt_i`=0 and `slow_dly_i`=D>0, the next cycle shows `vr_stop_no`=1 with `vr_sleep_o`=1. This holds for exactly D cycles, after which `vr_sleep_o` falls to 0.
- R3: The normal ramp shows `vr_stop_no`=1 and `vr_sleep_o`=0 for exactly RAMP_CYC cycles before the exit completes.
- R4: A `fast_evt_i` sampled during the slow window drives `vr_sleep_o` low in the next cycle, and a full normal ramp of RAMP_CYC cycles starts there.
- R5: When `fast_evt_i` and `slow_evt_i` are both high with the exit request, the normal path is taken.
- R6: With `slow_en_i`=0, every exit takes the normal path, whatever the event inputs are.
- R7: A programmed delay `slow_dly_i`=0 gives exactly the fast (normal) exit timing.
- R8: `exit_done_o` is high for one cycle, namely the first cycle after the ramp ends. From then on the outputs stay at `vr_stop_no`=1, `vr_sleep_o`=0.
- R9: `sleep_enter_i` is acted on only after the exit has completed. It then returns the block to the sleep levels in the next cycle. Outside that state it has no effect.
- R10: `exit_req_i` has no effect outside the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_enter_i | input | 1 | Request to re-enter deep sleep |
| exit_req_i | input | 1 | Request to start the exit sequence |
| slow_evt_i | input | 1 | Slow break-event strobe |
| fast_evt_i | input | 1 | Fast break-event strobe |
| slow_en_i | input | 1 | Enable for slow exit |
| slow_dly_i | input | DLY_W | Length in cycles of the slow window |
| vr_stop_no | output | 1 | Deep-stop control to regulator, active low |
| vr_sleep_o | output | 1 | Deep-sleep regulator control, active high |
| exit_done_o | output | 1 | One-cycle pulse when the exit completes |

## Verification
The assertions assume that all inputs are synchronous and held low during reset, so the first sampled history after reset is quiet. They also assume that `slow_en_i` and `slow_dly_i` only change while the block sleeps. The stimulus changes every input on the falling clock edge, keeps the configuration constant across each exit sequence, and pulses the event strobes for single cycles. A cycle-level behavioural model in the bench predicts all three outputs and is compared against them in every cycle.

// File: rtl/deep_exit_pkg.sv
package deep_exit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_C4     = 2'd0,
        ST_SLOW_WAIT   = 2'd1,
        ST_NORMAL_RAMP = 2'd2,
        ST_DONE        = 2'd3
    } exit_state_e;

    typedef struct packed {
        exit_state_e state;
        logic        done;
    } seq_regs_t;

    typedef struct packed {
        logic stop_n;
        logic sleep_vr;
    } vr_levels_t;

endpackage

// File: rtl/deep_exit_slow_timer.sv
module deep_exit_slow_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             last_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Last cycle of the window: the remaining count is one.
    assign last_o = run_i && (cnt_q == ONE);

endmodule

// File: rtl/deep_exit_ramp_timer.sv
module deep_exit_ramp_timer #(
    parameter int RAMP_CYC = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic last_o
);
    localparam int RW = (RAMP_CYC > 1) ? $clog2(RAMP_CYC) : 1;

    generate
        if (RAMP_CYC <= 1) begin : g_single
            // A one-cycle ramp ends in the cycle it starts.
            assign last_o = run_i;
        end else begin : g_count
            localparam logic [RW-1:0] LAST_VAL = RW'(RAMP_CYC - 1);
            logic [RW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (run_i && cnt_q != LAST_VAL) begin
                    cnt_d = cnt_q + RW'(1);
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign last_o = run_i && (cnt_q == LAST_VAL);
        end
    endgenerate

endmodule

// File: rtl/deep_exit_vr_decode.sv
module deep_exit_vr_decode
    import deep_exit_pkg::*;
(
    input  exit_state_e state_i,
    output vr_levels_t  lv_o
);
    always_comb begin
        unique case (state_i)
            ST_IDLE_C4:     lv_o = '{stop_n: 1'b0, sleep_vr: 1'b1};
            ST_SLOW_WAIT:   lv_o = '{stop_n: 1'b1, sleep_vr: 1'b1};
            ST_NORMAL_RAMP: lv_o = '{stop_n: 1'b1, sleep_vr: 1'b0};
            default:        lv_o = '{stop_n: 1'b1, sleep_vr: 1'b0};
        endcase
    end
endmodule

// File: rtl/deep_exit_seq.sv
module deep_exit_seq
    import deep_exit_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int RAMP_CYC = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sleep_enter_i,
    input  logic             exit_req_i,
    input  logic             slow_evt_i,
    input  logic             fast_evt_i,
    input  logic             slow_en_i,
    input  logic [DLY_W-1:0] slow_dly_i,
    output logic             vr_stop_no,
    output logic             vr_sleep_o,
    output logic             exit_done_o
);
    seq_regs_t  r_d, r_q;
    vr_levels_t lv;
    logic       slow_load, slow_last;
    logic       ramp_clear, ramp_last;
    logic       take_slow;

    // Slow path only when enabled, slow event alone, and a non-zero window.
    assign take_slow = slow_en_i && slow_evt_i && !fast_evt_i && (slow_dly_i != '0);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        slow_load  = 1'b0;
        ramp_clear = 1'b0;
        unique case (r_q.state)
            ST_IDLE_C4: begin
                if (exit_req_i) begin
                    if (take_slow) begin
                        r_d.state = ST_SLOW_WAIT;
                        slow_load = 1'b1;
                    end else begin
                        r_d.state  = ST_NORMAL_RAMP;
                        ramp_clear = 1'b1;
                    end
                end
            end
            ST_SLOW_WAIT: begin
                if (fast_evt_i || slow_last) begin
                    r_d.state  = ST_NORMAL_RAMP;
                    ramp_clear = 1'b1;
                end
            end
            ST_NORMAL_RAMP: begin
                if (ramp_last) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                if (sleep_enter_i) begin
                    r_d.state = ST_IDLE_C4;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE_C4, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    deep_exit_slow_timer #(.DLY_W(DLY_W)) u_slow (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (slow_load),
        .load_val_i (slow_dly_i),
        .run_i      (r_q.state == ST_SLOW_WAIT),
        .last_o     (slow_last)
    );

    deep_exit_ramp_timer #(.RAMP_CYC(RAMP_CYC)) u_ramp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ramp_clear),
        .run_i   (r_q.state == ST_NORMAL_RAMP),
        .last_o  (ramp_last)
    );

    deep_exit_vr_decode u_dec (
        .state_i (r_q.state),
        .lv_o    (lv)
    );

    assign vr_stop_no  = lv.stop_n;
    assign vr_sleep_o  = lv.sleep_vr;
    assign exit_done_o = r_q.done;

endmodule

// File: rtl/deep_exit_seq_chk.sv
module deep_exit_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sleep_enter_i,
    input logic exit_req_i,
    input logic fast_evt_i,
    input logic slow_en_i,
    input logic vr_stop_no,
    input logic vr_sleep_o,
    input logic exit_done_o
);
    // R9: the sleep levels come back only after a sleep-entry request.
    a_r9_stop_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(vr_stop_no) |-> $past(sleep_enter_i) && vr_sleep_o);

    // R1: the deep-sleep line only rises when re-entering sleep.
    a_r1_sleep_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vr_sleep_o) |-> !vr_stop_no);

    // R10: leaving the sleep levels needs an exit request.
    a_r10_exit_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vr_stop_no) |-> $past(exit_req_i));

    // R6: no slow window when slow exit is disabled.
    a_r6_no_slow_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(vr_stop_no) && !$past(slow_en_i)) |-> !vr_sleep_o);

    // R4: a fast event in the slow window drops the deep-sleep line next cycle.
    a_r4_fast_cuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vr_stop_no && vr_sleep_o && fast_evt_i) |=> !vr_sleep_o);

    // R8: done is a single-cycle pulse with the awake levels.
    a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exit_done_o |=> !exit_done_o);

    a_r8_done_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exit_done_o |-> vr_stop_no && !vr_sleep_o);

endmodule

bind deep_exit_seq deep_exit_seq_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_enter_i (sleep_enter_i),
    .exit_req_i    (exit_req_i),
    .fast_evt_i    (fast_evt_i),
    .slow_en_i     (slow_en_i),
    .vr_stop_no    (vr_stop_no),
    .vr_sleep_o    (vr_sleep_o),
    .exit_done_o   (exit_done_o)
);

// File: tb/deep_exit_seq_test.sv
module deep_exit_seq_test;
    localparam int DLY_W    = 8;
    localparam int RAMP_CYC = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_enter = 1'b0;
    logic             exit_req = 1'b0;
    logic             slow_evt = 1'b0;
    logic             fast_evt = 1'b0;
    logic             slow_en = 1'b0;
    logic [DLY_W-1:0] slow_dly = '0;
    logic             stop_n, sleep_vr, done;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    finished = 0;
    string tag = "R1";

    // Behavioural model: 0 sleeping, 1 slow window, 2 ramp, 3 awake.
    int m_phase = 0;
    int m_left  = 0;
    bit m_done  = 0;

    always #2 clk = ~clk;

    deep_exit_seq #(.DLY_W(DLY_W), .RAMP_CYC(RAMP_CYC)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sleep_enter_i (sleep_enter),
        .exit_req_i    (exit_req),
        .slow_evt_i    (slow_evt),
        .fast_evt_i    (fast_evt),
        .slow_en_i     (slow_en),
        .slow_dly_i    (slow_dly),
        .vr_stop_no    (stop_n),
        .vr_sleep_o    (sleep_vr),
        .exit_done_o   (done)
    );

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_phase = 0;
            m_done  = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (exit_req) begin
                    if (slow_en && slow_evt && !fast_evt && slow_dly != 0) begin
                        m_phase = 1;
                        m_left  = int'(slow_dly);
                    end else begin
                        m_phase = 2;
                        m_left  = RAMP_CYC;
                    end
                end
                1: begin
                    if (fast_evt) begin
                        m_phase = 2;
                        m_left  = RAMP_CYC;
                    end else begin
                        m_left = m_left - 1;
                        if (m_left == 0) begin
                            m_phase = 2;
                            m_left  = RAMP_CYC;
                        end
                    end
                end
                2: begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        m_phase = 3;
                        m_done  = 1;
                    end
                end
                default: if (sleep_enter) m_phase = 0;
            endcase
        end
    end

    task automatic cyc();
        logic [2:0] act, exp;
        @(negedge clk);
        act = {stop_n, sleep_vr, done};
        exp = {(m_phase != 0), (m_phase <= 1), m_done};
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s cycle %0d: {stop_n,sleep_vr,done} actual=%b expected=%b",
                     tag, cycles, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic start_exit(input bit s, input bit f);
        exit_req = 1'b1; slow_evt = s; fast_evt = f;
        cyc();
        exit_req = 1'b0; slow_evt = 1'b0; fast_evt = 1'b0;
    endtask

    task automatic reenter();
        sleep_enter = 1'b1;
        cyc();
        sleep_enter = 1'b0;
        idle(2);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cycles);
        report();
    end

    initial begin
        tag = "R1"; idle(3);
        rst_n = 1'b1; idle(3);

        // R6: slow disabled, slow event still gives normal timing
        tag = "R6"; slow_en = 1'b0; slow_dly = 8'd5;
        start_exit(1'b1, 1'b0); idle(RAMP_CYC + 3);
        tag = "R9"; reenter();

        // R2, R3, R8: slow window of 5 then full ramp and done pulse
        tag = "R2"; slow_en = 1'b1; slow_dly = 8'd5;
        start_exit(1'b1, 1'b0); idle(5);
        tag = "R3"; idle(RAMP_CYC);
        tag = "R8"; idle(4);
        tag = "R9"; reenter();

        // R4: fast event in the middle of a slow window of 20
        tag = "R4"; slow_dly = 8'd20;
        start_exit(1'b1, 1'b0); idle(4);
        fast_evt = 1'b1; cyc(); fast_evt = 1'b0;
        idle(RAMP_CYC + 3);
        tag = "R9"; reenter();

        // R5: both events at the request
        tag = "R5"; start_exit(1'b1, 1'b1); idle(RAMP_CYC + 2);
        tag = "R9"; reenter();

        // R7: zero delay behaves like a fast exit
        tag = "R7"; slow_dly = 8'd0;
        start_exit(1'b1, 1'b0); idle(RAMP_CYC + 2);
        tag = "R9"; reenter();

        // R10: exit request ignored in slow window and when awake
        tag = "R10"; slow_dly = 8'd3;
        start_exit(1'b1, 1'b0);
        exit_req = 1'b1; cyc(); exit_req = 1'b0;
        idle(2 + RAMP_CYC + 1);
        exit_req = 1'b1; cyc(); exit_req = 1'b0; idle(2);

        // R9: sleep entry ignored during the slow window and the ramp
        tag = "R9"; reenter();
        slow_dly = 8'd4; start_exit(1'b1, 1'b0);
        sleep_enter = 1'b1; cyc(); sleep_enter = 1'b0;
        idle(4);
        sleep_enter = 1'b1; cyc(); sleep_enter = 1'b0;
        idle(RAMP_CYC + 2);
        reenter();

        // R2: slow window of one cycle
        tag = "R2"; slow_dly = 8'd1;
        start_exit(1'b1, 1'b0); idle(RAMP_CYC + 3);
        tag = "R9"; reenter();

        report();
    end
endmodule